// File: doc/BRIEF.md
# Modulo Reload Timer with Prescaler

A 16-bit up-counting timer, programmed through a simple 32-bit register port, that serves as a periodic system tick or as a one-shot event source. The counter runs from a programmable start value up to a programmable modulo value. On the next step after the modulo value it reloads the start value and raises an overflow flag. That flag can drive a level interrupt.

A control register sets the counting source and a power-of-two prescaler, and it holds the interrupt enable and the overflow flag. The counting source can be off, every system clock, or an external tick-enable strobe. Writes to the modulo and start-value registers go into a holding buffer. The values that the counter uses take the buffered contents only while the source field is off. Software therefore stops the timer, reprograms it, and restarts it, and the counter never sees a half-updated limit. Writing anything to the counter register restarts the count from the committed start value.

Top module: `modulo_tick_timer`

## Requirements
- R1: After reset the control register reads 0, the counter reads 0, the modulo register reads 0x0000FFFF, the start value reads 0 and `irq` is low.
- R2: With the source field (control bits 4:3) at 0 the counter holds its value.
- R3: With source 1 the counter advances once every 2^P clock cycles, where P is control bits 2:0 (0 to 7).
- R4: When the counter equals the modulo value, its next advance loads the start value and sets the overflow flag (control bit 7). A period of N advances therefore needs a modulo of start+N-1.
- R5: A write of any data to the counter register (offset 0x04) loads the committed start value.
- R6: Writes to modulo (0x08) and start value (0x4C) take effect only while the source field is 0. Until then, reads return the previously committed value. Only the low 16 bits are kept, and the upper 16 read as zero.
- R7: The flag clears only when a control read has seen it at 1 and a later control write has bit 7 at 0. A write with bit 7 at 1, or a write of 0 without that read, leaves it set.
- R8: `irq` is high exactly while the overflow flag and the interrupt enable (control bit 6) are both 1.
- R9: A control write that changes the prescaler or the source field restarts the prescaler division from zero, and that write cycle does not advance the counter.
- R10: Source 2 advances the counter only in cycles with `ext_tick` high (subject to the prescaler). Source 3 holds the counter and does not commit buffered writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (used for the flag-seen state) |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| ext_tick | input | 1 | Tick enable used by source 2 |
| irq | output | 1 | Level overflow interrupt |

## Verification
The bench builds the block with its default parameters: a 16-bit counter and a 3-bit prescaler exponent. The random part uses exponents 0 to 3 and short modulo spans, so that several wraps and flag settings happen inside each run of at most 60 cycles. Directed cases cover the stopped, external and halted sources, the commit of the buffered registers, the read-then-clear flag protocol, and the restart of the prescaler division part-way through a division.

// File: rtl/mtt_pkg.sv
package mtt_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_CNT  = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_MOD  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_INIT = 8'h4C;

    // Control bit positions (software decodes these)
    localparam int PS_LSB   = 0;
    localparam int SRC_LSB  = 3;
    localparam int IE_BIT   = 6;
    localparam int FLAG_BIT = 7;

    typedef enum logic [1:0] {
        SRC_OFF  = 2'd0,
        SRC_SYS  = 2'd1,
        SRC_EXT  = 2'd2,
        SRC_HALT = 2'd3
    } src_e;

    typedef struct packed {
        logic       flag;
        logic       ie;
        src_e       src;
        logic [2:0] ps;
    } ctrl_t;

    function automatic logic src_tick(src_e s, logic ext);
        return (s == SRC_SYS) || ((s == SRC_EXT) && ext);
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(ctrl_t c);
        logic [REG_W-1:0] v;
        v = '0;
        v[FLAG_BIT]          = c.flag;
        v[IE_BIT]            = c.ie;
        v[SRC_LSB+1:SRC_LSB] = c.src;
        v[PS_LSB+2:PS_LSB]   = c.ps;
        return v;
    endfunction

endpackage

// File: rtl/mtt_prescaler.sv
module mtt_prescaler #(
    parameter int PS_W = 3,
    localparam int DIV_W = (1 << PS_W) - 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            restart,
    input  logic            tick,
    input  logic [PS_W-1:0] ps,
    output logic            adv
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] limit;

    always_comb begin
        limit = '0;
        for (int i = 0; i < DIV_W; i++) begin
            limit[i] = (i < int'(ps));
        end
    end

    assign adv = tick && !restart && (div_q == limit);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            div_q <= '0;
        end else if (tick) begin
            if (div_q == limit) div_q <= '0;
            else                div_q <= div_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/mtt_shadow_reg.sv
module mtt_shadow_reg #(
    parameter int W = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         commit,
    output logic [W-1:0] active
);
    logic [W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= RST_VAL;
            active <= RST_VAL;
        end else begin
            if (wr)     hold_q <= wdata;
            if (commit) active <= hold_q;
        end
    end
endmodule

// File: rtl/mtt_count_core.sv
module mtt_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             adv,
    input  logic [CNT_W-1:0] mod_val,
    input  logic [CNT_W-1:0] init_val,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    assign wrap = adv && !load && (cnt == mod_val);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= init_val;
        else if (wrap) cnt <= init_val;
        else if (adv)  cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/modulo_tick_timer.sv
module modulo_tick_timer
    import mtt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PS_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              ext_tick,
    output logic              irq
);
    localparam logic [CNT_W-1:0] MOD_RST = {CNT_W{1'b1}};

    ctrl_t            ctrl_q;
    logic             seen_q;
    logic             ctrl_wr, cnt_wr, mod_wr, init_wr, ctrl_rd;
    logic             restart, tick, adv, wrap, commit, flag_clr;
    logic [2:0]       wr_ps;
    src_e             wr_src;
    logic [CNT_W-1:0] cnt_q, mod_act, init_act;
    logic             bits_unused;

    assign bits_unused = ^{reg_wdata[REG_W-1:CNT_W], reg_wdata[5]};

    assign ctrl_wr = reg_wr && (reg_addr == OFF_CTRL);
    assign cnt_wr  = reg_wr && (reg_addr == OFF_CNT);
    assign mod_wr  = reg_wr && (reg_addr == OFF_MOD);
    assign init_wr = reg_wr && (reg_addr == OFF_INIT);
    assign ctrl_rd = reg_rd && (reg_addr == OFF_CTRL);

    assign wr_ps   = reg_wdata[PS_LSB+2:PS_LSB];
    assign wr_src  = src_e'(reg_wdata[SRC_LSB+1:SRC_LSB]);
    assign restart = ctrl_wr && ((wr_ps != ctrl_q.ps) || (wr_src != ctrl_q.src));
    assign tick    = src_tick(ctrl_q.src, ext_tick);
    assign commit  = (ctrl_q.src == SRC_OFF);
    assign flag_clr = ctrl_wr && !reg_wdata[FLAG_BIT] && seen_q;

    mtt_prescaler #(.PS_W(PS_W)) u_pre (
        .clk(clk), .rst(rst), .restart(restart), .tick(tick),
        .ps(ctrl_q.ps[PS_W-1:0]), .adv(adv)
    );

    mtt_shadow_reg #(.W(CNT_W), .RST_VAL(MOD_RST)) u_mod (
        .clk(clk), .rst(rst), .wr(mod_wr), .wdata(reg_wdata[CNT_W-1:0]),
        .commit(commit), .active(mod_act)
    );

    mtt_shadow_reg #(.W(CNT_W), .RST_VAL('0)) u_init (
        .clk(clk), .rst(rst), .wr(init_wr), .wdata(reg_wdata[CNT_W-1:0]),
        .commit(commit), .active(init_act)
    );

    mtt_count_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .load(cnt_wr), .adv(adv),
        .mod_val(mod_act), .init_val(init_act), .cnt(cnt_q), .wrap(wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{flag: 1'b0, ie: 1'b0, src: SRC_OFF, ps: 3'd0};
            seen_q <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q.ie  <= reg_wdata[IE_BIT];
                ctrl_q.src <= wr_src;
                ctrl_q.ps  <= wr_ps;
            end
            if (wrap)          ctrl_q.flag <= 1'b1;
            else if (flag_clr) ctrl_q.flag <= 1'b0;
            if (flag_clr && !wrap)           seen_q <= 1'b0;
            else if (ctrl_rd && ctrl_q.flag) seen_q <= 1'b1;
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFF_CTRL: reg_rdata = pack_ctrl(ctrl_q);
            OFF_CNT:  reg_rdata = REG_W'(cnt_q);
            OFF_MOD:  reg_rdata = REG_W'(mod_act);
            OFF_INIT: reg_rdata = REG_W'(init_act);
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = ctrl_q.flag && ctrl_q.ie;
endmodule

// File: rtl/mtt_checker.sv
module mtt_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       src,
    input logic [2:0]       ps,
    input logic             cnt_wr,
    input logic             restart,
    input logic             flag,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] mod_act,
    input logic [CNT_W-1:0] init_act
);
    assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (rst)
        (src == 2'd0 && !cnt_wr) |=> $stable(cnt));

    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
        (src == 2'd1 && ps == 3'd0 && !cnt_wr && !restart && cnt != mod_act)
        |=> (cnt == $past(cnt) + CNT_W'(1)));

    assert_wrap_flag_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> ($past(cnt) == $past(mod_act) && cnt == $past(init_act)));

    assert_cnt_load_R5: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (cnt == $past(init_act)));

    assert_commit_off_R6: assert property (@(posedge clk) disable iff (rst)
        (!$stable(mod_act) || !$stable(init_act)) |-> ($past(src) == 2'd0));
endmodule

bind modulo_tick_timer mtt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .src(ctrl_q.src), .ps(ctrl_q.ps), .cnt_wr(cnt_wr),
    .restart(restart), .flag(ctrl_q.flag), .cnt(cnt_q),
    .mod_act(mod_act), .init_act(init_act)
);

// File: tb/modulo_tick_timer_tb.sv
`timescale 1ns/1ps
module modulo_tick_timer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, ext_tick = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    int          checks = 0, errors = 0;
    bit          done = 0;

    localparam logic [7:0] A_CTRL = 8'h00, A_CNT = 8'h04, A_MOD = 8'h08, A_INIT = 8'h4C;

    always #2.5 clk = ~clk;

    modulo_tick_timer u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_tick(ext_tick), .irq(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk); @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic logic [31:0] exp_cnt(int i0, int m, int p, int n);
        int adv = n >> p;
        return 32'(i0 + adv % (m - i0 + 1));
    endfunction

    function automatic logic exp_flag(int i0, int m, int p, int n);
        return (n >> p) >= (m - i0 + 1);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        rd(A_CTRL, d); chk("R1 ctrl", d, 32'h0);
        rd(A_CNT, d);  chk("R1 cnt", d, 32'h0);
        rd(A_MOD, d);  chk("R1 mod", d, 32'h0000FFFF);
        rd(A_INIT, d); chk("R1 init", d, 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);

        // R4 wrap, R7 clear protocol, R8 irq level, R2 stop
        wr(A_INIT, 32'h0); wr(A_MOD, 32'h3); cyc(1);
        wr(A_CTRL, 32'h08);              // edge E
        cyc(3);
        rd(A_CNT, d); chk("R4 reached modulo", d, 32'h3);   // wrap at E+4
        wr(A_CTRL, 32'h00);              // no prior read: flag stays
        cyc(5);
        rd(A_CNT, d); chk("R4 reload to start / R2 stopped", d, 32'h0);
        rd(A_CTRL, d); chk("R7 write0 without read keeps flag", d, 32'h80);
        chk("R8 irq low with ie=0", 32'(irq), 32'h0);
        wr(A_CTRL, 32'hC0);
        chk("R8 irq high", 32'(irq), 32'h1);
        rd(A_CTRL, d); chk("R7 write1 keeps flag", d, 32'hC0);
        wr(A_CTRL, 32'h40);
        chk("R8 irq drops after clear", 32'(irq), 32'h0);
        rd(A_CTRL, d); chk("R7 cleared", d, 32'h40);
        wr(A_CTRL, 32'h00);

        // R5 counter write loads start value
        wr(A_INIT, 32'h5); cyc(1);
        wr(A_CNT, 32'hBEEF);
        rd(A_CNT, d); chk("R5 load start", d, 32'h5);

        // R6 buffering
        wr(A_CTRL, 32'h08);
        wr(A_MOD, 32'hABCD1234);
        rd(A_MOD, d); chk("R6 not committed while running", d, 32'h3);
        wr(A_CTRL, 32'h00); cyc(1);
        rd(A_MOD, d); chk("R6 committed, upper zero", d, 32'h00001234);

        // R9 prescaler restart
        wr(A_INIT, 32'h0); wr(A_MOD, 32'hFFFF); cyc(1);
        wr(A_CNT, 32'h0);
        wr(A_CTRL, 32'h0A);              // edge E, ps=2
        cyc(5);                          // advance at E+4, div=1 after E+5
        wr(A_CTRL, 32'h0B);              // edge E+6, ps=3, restart
        cyc(7);
        rd(A_CNT, d); chk("R9 no early advance", d, 32'h1);
        rd(A_CNT, d); chk("R9 advance after full division", d, 32'h2);

        // R10 external ticks and halt
        wr(A_CTRL, 32'h00); wr(A_CNT, 32'h0);
        wr(A_CTRL, 32'h10);
        cyc(4);
        rd(A_CNT, d); chk("R10 ext idle", d, 32'h0);
        ext_tick = 1'b1; cyc(3); ext_tick = 1'b0;
        rd(A_CNT, d); chk("R10 ext three ticks", d, 32'h3);
        wr(A_CTRL, 32'h18);
        ext_tick = 1'b1;
        wr(A_MOD, 32'h7);
        cyc(4);
        rd(A_CNT, d); chk("R10 halt source holds", d, 32'h3);
        rd(A_MOD, d); chk("R10/R6 halt source no commit", d, 32'h0000FFFF);
        ext_tick = 1'b0;
        wr(A_CTRL, 32'h00);

        // R3/R4 random periods and prescalers
        for (int it = 0; it < 12; it++) begin
            int i0 = int'($urandom % 1000);
            int m  = i0 + int'($urandom % 20);
            int p  = int'($urandom % 4);
            int n  = 1 + int'($urandom % 60);
            logic fl;
            rd(A_CTRL, d); wr(A_CTRL, 32'h00);
            wr(A_INIT, 32'(i0)); wr(A_MOD, 32'(m)); cyc(1);
            wr(A_CNT, 32'h0);
            wr(A_CTRL, 32'h48 | 32'(p));     // edge E
            cyc(n);
            rd(A_CNT, d); chk("R3 random count", d, exp_cnt(i0, m, p, n));
            fl = exp_flag(i0, m, p, n + 1);
            reg_rd = 1'b1; reg_addr = A_CTRL;
            #1 chk("R4 random flag", reg_rdata, {24'h0, fl, 7'h48} | 32'(p));
            chk("R8 random irq", 32'(irq), 32'(fl));
            @(posedge clk); @(negedge clk); reg_rd = 1'b0;
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule